// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block lets a host run word-level commands on a three-wire serial EEPROM. The three wires are select, shift clock and serial data in, plus a data-out return line. The host pulses a start input with an opcode, a word address, a data word and an address-width select. The engine then builds the serial frame and shifts it out MSB first, capturing the returned bit at every clock pulse. It finishes with a one-cycle done pulse and the result on its outputs.

Programming commands (write and erase) run the whole handshake without help from the host:
1. Wait for ready.
2. Unlock the device.
3. Send the command.
4. Wait for ready.
5. Lock the device.
6. Wait for ready.

Each wait polls the data-out line with select held high and gives up after a bounded number of cycles. A probe command sends a long read with eight zero address bits and decides from the response whether the device uses 8-bit or 6-bit word addresses.

Top module: `ee_cmd_engine`

## Requirements
- R1: Opcode encoding on `op_i`: 0 read, 1 write, 2 erase, 3 unlock (write-enable), 4 lock (write-disable), 5 ready-poll, 6 size probe. Every frame of L payload bits is sent as L+1 shift-clock pulses. The first pulse carries a zero and the payload follows MSB first. A read payload is start+opcode bits `110`, then the address, then 16 zeros, so L = 19 + address width.
- R2: After a read, `rdata_o` holds the last 16 bits sampled from `ee_do_i`, with the last sample as bit 0. It is valid when `done_o` pulses.
- R3: A write payload is `101`, the address, then the 16-bit data word, MSB first. An erase payload is `111` followed by the address, with L = 3 + address width.
- R4: The unlock payload is `1001111` shifted left by (address width − 4). The lock payload is `1000000` shifted the same way. Both have L = 3 + address width.
- R5: `ee_di_o` changes only while `ee_sk_o` is low. Each low and each high clock phase lasts `CLK_DIV` cycles. `ee_sk_o` is high only while `ee_cs_o` is high. Select is high for the whole of a frame and goes low after its last bit.
- R6: Write and erase run these steps in order: poll, unlock frame, command frame, poll, lock frame, poll. Each step is a separate select session.
- R7: A poll holds `ee_cs_o` high with the clock low until `ee_do_i` is sampled high. `poll_cnt_o` then gives the number of samples that were low.
- R8: When a poll sees `POLL_LIMIT` low samples, the command is aborted and `timeout_o` is set. `poll_cnt_o` equals `POLL_LIMIT`. `timeout_o` stays set until the next accepted start.
- R9: The probe sends a 27-bit payload: `110` followed by 24 zeros. `probe_addr8_o` becomes 1 when captured result bits 27 down to 17 are all ones, and 0 otherwise.
- R10: A start is accepted only while `busy_o` is low. A start raised during a command has no effect. `done_o` is high for exactly one cycle per command.
- R11: `addr8_i` = 1 selects 8 address bits (`addr_i[7:0]`). `addr8_i` = 0 selects 6 bits (`addr_i[5:0]`), and the upper two bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command request pulse |
| op_i | input | 3 | Command code (see R1) |
| addr_i | input | 8 | Word address |
| wdata_i | input | 16 | Data word for write |
| addr8_i | input | 1 | 1: 8-bit addresses, 0: 6-bit addresses |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Word returned by the last read |
| timeout_o | output | 1 | A poll expired in the last command |
| poll_cnt_o | output | $clog2(POLL_LIMIT+1) | Low samples seen by the last poll |
| probe_addr8_o | output | 1 | Probe result: device uses 8-bit addresses |
| ee_cs_o | output | 1 | Device select |
| ee_sk_o | output | 1 | Device shift clock |
| ee_di_o | output | 1 | Serial data to the device |
| ee_do_i | input | 1 | Serial data from the device |

## Verification
The bench builds the engine with `CLK_DIV` = 2 and `POLL_LIMIT` = 40. The short poll limit means the abort path of a program sequence and the exact expiry count can be reached within a few dozen cycles, instead of ten thousand. With two-cycle phases, each bit stays on the wires long enough for the bench's device model to answer after a clock rise, before the engine samples. It also lets the bench measure that every clock phase is exactly two cycles long.

// File: rtl/ee_cmd_pkg.sv
package ee_cmd_pkg;
  localparam int FRAME_W = 28;
  localparam int NB_W    = 5;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_WEN   = 3'd3,
    OP_WDS   = 3'd4,
    OP_POLL  = 3'd5,
    OP_PROBE = 3'd6
  } ee_op_e;

  typedef enum logic [1:0] {ST_FRAME, ST_POLL, ST_END} ee_step_e;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [NB_W-1:0]    nbits;
  } ee_frame_t;

  typedef struct packed {
    ee_step_e kind;
    ee_op_e   fop;
  } ee_step_t;

  // Payload left-aligned below one leading zero bit; nbits counts that bit too.
  function automatic ee_frame_t build_frame(ee_op_e op, logic [7:0] addr,
                                            logic [15:0] data, logic a8);
    ee_frame_t f;
    logic [FRAME_W-1:0] v;
    logic [FRAME_W-1:0] a;
    int unsigned aw;
    int unsigned len;
    aw = a8 ? 8 : 6;
    a  = a8 ? FRAME_W'(addr) : FRAME_W'(addr[5:0]);
    case (op)
      OP_READ: begin
        v   = ((FRAME_W'(6) << aw) | a) << 16;
        len = 19 + aw;
      end
      OP_WRITE: begin
        v   = (((FRAME_W'(5) << aw) | a) << 16) | FRAME_W'(data);
        len = 19 + aw;
      end
      OP_ERASE: begin
        v   = (FRAME_W'(7) << aw) | a;
        len = 3 + aw;
      end
      OP_WEN: begin
        v   = FRAME_W'(7'h4F) << (aw - 4);
        len = 3 + aw;
      end
      OP_WDS: begin
        v   = FRAME_W'(7'h40) << (aw - 4);
        len = 3 + aw;
      end
      default: begin
        v   = FRAME_W'(6) << 24;
        len = 27;
      end
    endcase
    f.bits  = v << (FRAME_W - 1 - len);
    f.nbits = NB_W'(len + 1);
    return f;
  endfunction

  function automatic ee_step_t step_of(ee_op_e op, logic [2:0] idx);
    ee_step_t s;
    s.kind = ST_END;
    s.fop  = op;
    if (op == OP_WRITE || op == OP_ERASE) begin
      case (idx)
        3'd0: s.kind = ST_POLL;
        3'd1: begin s.kind = ST_FRAME; s.fop = OP_WEN; end
        3'd2: s.kind = ST_FRAME;
        3'd3: s.kind = ST_POLL;
        3'd4: begin s.kind = ST_FRAME; s.fop = OP_WDS; end
        3'd5: s.kind = ST_POLL;
        default: s.kind = ST_END;
      endcase
    end else if (op == OP_POLL) begin
      s.kind = (idx == 3'd0) ? ST_POLL : ST_END;
    end else begin
      s.kind = (idx == 3'd0) ? ST_FRAME : ST_END;
    end
    return s;
  endfunction
endpackage

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ee_frame_shifter.sv
module ee_frame_shifter
  import ee_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  ee_frame_t   frame_i,
  input  logic        tick_i,
  input  logic        sdo_i,
  output logic        sk_o,
  output logic        di_o,
  output logic        last_o,
  output logic [15:0] word_o,
  output logic        ones_o
);
  logic [FRAME_W-1:0] sr_q, res_q;
  logic [NB_W-1:0]    left_q;
  logic               ph_q, act_q;

  assign last_o = act_q && tick_i && ph_q && (left_q == NB_W'(1));
  assign sk_o   = act_q && ph_q;
  assign di_o   = act_q && sr_q[FRAME_W-1];
  assign word_o = res_q[15:0];
  assign ones_o = &res_q[FRAME_W-1:FRAME_W-11];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      res_q  <= '0;
      left_q <= '0;
      ph_q   <= 1'b0;
      act_q  <= 1'b0;
    end else if (load_i) begin
      sr_q   <= frame_i.bits;
      left_q <= frame_i.nbits;
      res_q  <= '0;
      ph_q   <= 1'b0;
      act_q  <= 1'b1;
    end else if (act_q && tick_i) begin
      if (!ph_q) begin
        ph_q <= 1'b1;
      end else begin
        // sample after the rise, then drop clock and present next bit
        ph_q   <= 1'b0;
        sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
        res_q  <= {res_q[FRAME_W-2:0], sdo_i};
        left_q <= left_q - 1'b1;
        if (left_q == NB_W'(1)) act_q <= 1'b0;
      end
    end
  end

  // R5
  di_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o && $past(sk_o)) |-> $stable(di_o));
  // R5
  di_at_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sk_o) |-> $stable(di_o));
endmodule

// File: rtl/ee_ready_poll.sv
module ee_ready_poll #(
  parameter int LIMIT = 10000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          sdo_i,
  output logic          ready_o,
  output logic          expire_o,
  output logic [CW-1:0] count_o
);
  logic          act_q;
  logic [CW-1:0] cnt_q;

  assign ready_o  = act_q && sdo_i;
  assign expire_o = act_q && !sdo_i && (cnt_q == CW'(LIMIT - 1));
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (sdo_i) begin
        act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (expire_o) act_q <= 1'b0;
      end
    end
  end

  // R7
  poll_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(LIMIT));
  // R8
  poll_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !start_i && (sdo_i || expire_o)) |=> !act_q);
endmodule

// File: rtl/ee_cmd_engine.sv
module ee_cmd_engine
  import ee_cmd_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int POLL_LIMIT = 10000,
  localparam int PCW = $clog2(POLL_LIMIT + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2:0]     op_i,
  input  logic [7:0]     addr_i,
  input  logic [15:0]    wdata_i,
  input  logic           addr8_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [15:0]    rdata_o,
  output logic           timeout_o,
  output logic [PCW-1:0] poll_cnt_o,
  output logic           probe_addr8_o,
  output logic           ee_cs_o,
  output logic           ee_sk_o,
  output logic           ee_di_o,
  input  logic           ee_do_i
);
  typedef enum logic [2:0] {S_IDLE, S_DISP, S_FRAME, S_POLL, S_GAP, S_DONE} state_e;

  state_e      state_q;
  ee_op_e      op_q;
  logic [7:0]  addr_q;
  logic [15:0] data_q;
  logic        a8_q;
  logic [2:0]  step_q;
  logic        abort_q;
  logic        tmo_q;
  logic [15:0] rdata_q;
  logic        probe_q;

  ee_step_t    cur;
  ee_frame_t   frame;
  logic        tick, load, poll_go, last, ready, expire, ones;
  logic [15:0] word;

  always_comb begin
    cur   = step_of(op_q, step_q);
    frame = build_frame(cur.fop, addr_q, data_q, a8_q);
  end

  assign load    = (state_q == S_DISP) && (cur.kind == ST_FRAME);
  assign poll_go = (state_q == S_DISP) && (cur.kind == ST_POLL);

  ee_phase_timer #(.DIV(CLK_DIV)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   ((state_q == S_FRAME) || (state_q == S_GAP)),
    .tick_o (tick)
  );

  ee_frame_shifter i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .frame_i (frame),
    .tick_i  (tick),
    .sdo_i   (ee_do_i),
    .sk_o    (ee_sk_o),
    .di_o    (ee_di_o),
    .last_o  (last),
    .word_o  (word),
    .ones_o  (ones)
  );

  ee_ready_poll #(.LIMIT(POLL_LIMIT)) i_poll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (poll_go),
    .sdo_i    (ee_do_i),
    .ready_o  (ready),
    .expire_o (expire),
    .count_o  (poll_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      data_q  <= '0;
      a8_q    <= 1'b0;
      step_q  <= '0;
      abort_q <= 1'b0;
      tmo_q   <= 1'b0;
      rdata_q <= '0;
      probe_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          op_q    <= ee_op_e'(op_i);
          addr_q  <= addr_i;
          data_q  <= wdata_i;
          a8_q    <= addr8_i;
          step_q  <= '0;
          abort_q <= 1'b0;
          tmo_q   <= 1'b0;
          state_q <= S_DISP;
        end
        S_DISP: begin
          case (cur.kind)
            ST_FRAME: state_q <= S_FRAME;
            ST_POLL:  state_q <= S_POLL;
            default:  state_q <= S_DONE;
          endcase
        end
        S_FRAME: if (last) state_q <= S_GAP;
        S_POLL: begin
          if (ready) begin
            state_q <= S_GAP;
          end else if (expire) begin
            tmo_q   <= 1'b1;
            abort_q <= 1'b1;
            state_q <= S_GAP;
          end
        end
        S_GAP: if (tick) begin
          if (op_q == OP_READ)  rdata_q <= word;
          if (op_q == OP_PROBE) probe_q <= ones;
          if (abort_q) begin
            state_q <= S_DONE;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= S_DISP;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != S_IDLE);
  assign done_o        = (state_q == S_DONE);
  assign rdata_o       = rdata_q;
  assign timeout_o     = tmo_q;
  assign probe_addr8_o = probe_q;
  assign ee_cs_o       = (state_q == S_FRAME) || (state_q == S_POLL);

  // R5
  sk_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> ee_cs_o);
  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  tmo_in_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> busy_o);
  // R10
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(op_q));
endmodule

// File: tb/test_ee_cmd_engine.sv
module test_ee_cmd_engine;
  localparam int DIV = 2;
  localparam int LIM = 40;
  localparam int CW  = $clog2(LIM + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    op = '0;
  logic [7:0]    addr = '0;
  logic [15:0]   wdata = '0;
  logic          a8 = 1'b0;
  logic          busy, done, tmo, p8, cs, sk, di, sdo;
  logic [15:0]   rdata;
  logic [CW-1:0] pcnt;

  ee_cmd_engine #(.CLK_DIV(DIV), .POLL_LIMIT(LIM)) i_ee_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .addr8_i(a8), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .timeout_o(tmo), .poll_cnt_o(pcnt), .probe_addr8_o(p8), .ee_cs_o(cs),
    .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(sdo)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // device model
  logic        cs_q = 0, sk_q = 0, di_q = 0, do_bit = 0;
  logic [31:0] cap = 0;
  logic [31:0] resp_pat = 0;
  int          resp_len = 0, blen = 0, rises = 0, wcnt = 0;
  int          nsess = 0, di_viol = 0, hi_run = 0, hi_min = 1000, hi_max = 0;
  int          sess_cnt [0:255];
  logic [31:0] sess_bits [0:255];

  assign sdo = (rises != 0) ? do_bit : (wcnt >= blen);

  always @(posedge clk) begin
    cs_q <= cs; sk_q <= sk; di_q <= di;
    if (sk && sk_q && di != di_q) di_viol <= di_viol + 1;
    if (sk) hi_run <= hi_run + 1;
    else if (sk_q) begin
      if (hi_run < hi_min) hi_min <= hi_run;
      if (hi_run > hi_max) hi_max <= hi_run;
      hi_run <= 0;
    end
    if (cs && sk && !sk_q) begin
      cap    <= {cap[30:0], di};
      rises  <= rises + 1;
      do_bit <= resp_pat[(resp_len - rises) & 31];
    end
    if (cs && rises == 0) wcnt <= wcnt + 1;
    if (!cs && cs_q) begin
      if (nsess < 256) begin
        sess_cnt[nsess]  <= rises;
        sess_bits[nsess] <= cap;
      end
      nsess <= nsess + 1;
      rises <= 0; cap <= 0; wcnt <= 0;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act %0d cycles exp below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] app(logic [31:0] b, logic [31:0] v, int k);
    return (b << k) | (v & ((32'd1 << k) - 1));
  endfunction

  // expected frame: leading zero then payload (R1 R3 R4 R9 R11)
  function automatic logic [31:0] exp_bits(int o, logic [7:0] ad, logic [15:0] d,
                                           logic w8, output int n);
    int aw = w8 ? 8 : 6;
    logic [31:0] b = 0;
    case (o)
      0: begin b = app(b, 6, 3); b = app(b, ad, aw); b = app(b, 0, 16); n = 20 + aw; end
      1: begin b = app(b, 5, 3); b = app(b, ad, aw); b = app(b, d, 16); n = 20 + aw; end
      2: begin b = app(b, 7, 3); b = app(b, ad, aw); n = 4 + aw; end
      3: begin b = app(b, 4, 3); b = app(b, 15, 4); b = app(b, 0, aw - 4); n = 4 + aw; end
      4: begin b = app(b, 4, 3); b = app(b, 0, aw); n = 4 + aw; end
      default: begin b = app(b, 6, 3); b = app(b, 0, 24); n = 28; end
    endcase
    return b;
  endfunction

  task automatic chk_frame(string req, int idx, int o, logic [7:0] ad,
                           logic [15:0] d, logic w8);
    int n;
    logic [31:0] b = exp_bits(o, ad, d, w8, n);
    chk({req, " pulses"}, sess_cnt[idx], n);
    chk({req, " bits"}, sess_bits[idx], b);
  endtask

  task automatic run(int o, logic [7:0] ad, logic [15:0] d, logic w8,
                     logic [31:0] rp, int bl, output int base);
    bit seen = 0;
    base = nsess;
    resp_pat = rp; blen = bl;
    resp_len = (o == 6) ? 27 : (w8 ? 27 : 25);
    @(negedge clk);
    op = 3'(o); addr = ad; wdata = d; a8 = w8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    chk("R10 done seen", 32'(seen), 1);
  endtask

  task automatic chk_seq(int o, logic [7:0] ad, logic [15:0] d, logic w8, int base);
    if (o == 1 || o == 2) begin
      chk("R6 sessions", nsess - base, 6);
      chk("R6 poll1", sess_cnt[base], 0);
      chk_frame("R4 unlock", base + 1, 3, ad, d, w8);
      chk_frame("R3 cmd", base + 2, o, ad, d, w8);
      chk("R6 poll2", sess_cnt[base + 3], 0);
      chk_frame("R4 lock", base + 4, 4, ad, d, w8);
      chk("R6 poll3", sess_cnt[base + 5], 0);
    end else begin
      chk("R1 sessions", nsess - base, 1);
      chk_frame(o == 0 ? "R1 read" : (o == 6 ? "R9 probe" : "R4 frame"),
                base, o, ad, d, w8);
    end
  endtask

  initial begin
    int base;
    logic [31:0] rp;
    void'($urandom(32'h1234_5EED));
    repeat (3) @(negedge clk);
    chk("R10 reset busy", 32'(busy), 0);
    chk("R5 reset cs/sk", {cs, sk, di}, 0);
    chk("R2 reset rdata", 32'(rdata), 0);
    chk("R8 reset timeout", 32'(tmo), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: reads at both widths
    rp = $urandom();
    run(0, 8'h2A, 0, 0, rp, 0, base);
    chk_seq(0, 8'h2A, 0, 0, base);
    chk("R2 rdata 6b", 32'(rdata), 32'(rp[15:0]));
    @(negedge clk); chk("R10 done one cycle", 32'(done), 0);
    rp = $urandom();
    run(0, 8'hC3, 0, 1, rp, 0, base);
    chk_seq(0, 8'hC3, 0, 1, base);
    chk("R2 rdata 8b", 32'(rdata), 32'(rp[15:0]));
    // R11: upper address bits ignored at 6-bit width
    run(0, 8'hFF, 0, 0, 32'hFFFF_FFFF, 0, base);
    chk_frame("R11 narrow addr", base, 0, 8'h3F, 0, 0);

    // R3 R4 R6 R7: write and erase handshake
    run(1, 8'h15, 16'hBEEF, 0, 0, 5, base);
    chk_seq(1, 8'h15, 16'hBEEF, 0, base);
    chk("R7 poll count", 32'(pcnt), 5);
    chk("R8 no timeout", 32'(tmo), 0);
    run(2, 8'hA7, 0, 1, 0, 0, base);
    chk_seq(2, 8'hA7, 0, 1, base);
    chk("R7 immediate ready", 32'(pcnt), 0);
    run(3, 0, 0, 1, 0, 0, base);  chk_seq(3, 0, 0, 1, base);
    run(4, 0, 0, 0, 0, 0, base);  chk_seq(4, 0, 0, 0, base);

    // R7 standalone poll
    run(5, 0, 0, 0, 0, 7, base);
    chk("R7 poll session", nsess - base, 1);
    chk("R7 poll no clock", sess_cnt[base], 0);
    chk("R7 poll count 7", 32'(pcnt), 7);

    // R8 expiry, abort and clear
    run(5, 0, 0, 0, 0, 1000, base);
    chk("R8 timeout set", 32'(tmo), 1);
    chk("R8 count at limit", 32'(pcnt), LIM);
    run(1, 8'h01, 16'h1234, 0, 0, 1000, base);
    chk("R8 write aborted", nsess - base, 1);
    chk("R8 timeout write", 32'(tmo), 1);
    repeat (5) @(negedge clk);
    chk("R8 timeout held", 32'(tmo), 1);
    run(0, 8'h03, 0, 0, 0, 0, base);
    chk("R8 timeout cleared", 32'(tmo), 0);

    // R9 probe
    run(6, 0, 0, 0, 32'h0FFE_0000 | ($urandom() & 32'h1_FFFF), 0, base);
    chk_seq(6, 0, 0, 0, base);
    chk("R9 probe wide", 32'(p8), 1);
    run(6, 0, 0, 0, 32'h0FEE_0000, 0, base);
    chk("R9 probe narrow", 32'(p8), 0);

    // R10 start ignored while busy
    rp = $urandom();
    base = nsess;
    resp_pat = rp; blen = 0; resp_len = 25;
    @(negedge clk); op = 3'd0; addr = 8'h11; a8 = 0; start = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    op = 3'd1; start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 5000; i++) begin @(negedge clk); if (done) break; end
    repeat (10) @(negedge clk);
    chk("R10 busy start ignored", nsess - base, 1);
    chk("R10 read intact", 32'(rdata), 32'(rp[15:0]));

    // random mix
    for (int k = 0; k < 16; k++) begin
      int o = $urandom_range(4, 0);
      logic [7:0] ad = 8'($urandom());
      logic [15:0] d = 16'($urandom());
      logic w8 = 1'($urandom());
      int bl = $urandom_range(10, 0);
      rp = $urandom();
      run(o, ad, d, w8, rp, bl, base);
      chk_seq(o, w8 ? ad : {2'b00, ad[5:0]}, d, w8, base);
      if (o == 0) chk("R2 rdata rand", 32'(rdata), 32'(rp[15:0]));
      if (o == 1 || o == 2) chk("R7 poll rand", 32'(pcnt), bl);
    end

    chk("R5 di stable in high", di_viol, 0);
    chk("R5 high phase min", hi_min, DIV);
    chk("R5 high phase max", hi_max, DIV);
    summary();
    $finish;
  end
endmodule